// File: doc/BRIEF.md
# Multi-CPU Interrupt Pending-State Distributor

This block holds the pending state of every interrupt for each of up to eight processors in a small interrupt controller. Software changes that state through two write banks: a set bank and a clear bank. Each bank has 32-bit registers, and each bit stands for one interrupt ID. IDs 0 to 31 are private, so every CPU has its own copy of them. IDs from 32 upward are shared. Each shared ID carries a target mask that names the CPUs it is delivered to.

A write carries the number of the CPU that issued it and a secure flag. When security filtering is on, a non-secure write cannot touch an interrupt that belongs to group 0. A separate port rewrites the target mask of one shared interrupt, and the pending state moves with the mask. The block shows each CPU's pending view as a flat output vector. It also has a combinational read port that returns one register's worth of pending bits as seen by a given CPU.

Top module: `irq_pend_dist`

## Requirements
- R1: After reset, every bit of `pend_o` and `rd_data` is 0 and every target mask is empty.
- R2: A set write to register 0 sets the selected private IDs only in the copy of the CPU given by `wr_cpu`. The copies of the other CPUs do not change.
- R3: A clear write to register 0 clears the selected private IDs only in the copy of the CPU given by `wr_cpu`.
- R4: A set write to register n≥1 makes each selected shared ID (32·n + bit) pending on exactly the CPUs in its target mask. When the mask is empty, the write leaves no trace.
- R5: A clear write to register n≥1 removes the pending state of each selected shared ID from every CPU.
- R6: A target write (`tgt_en`) to a shared ID makes a pending interrupt pending on each CPU added to the mask and clears it on each CPU removed. An empty mask discards the pending state. Target writes to IDs below 32 have no effect.
- R7: When `sec_en`=1 and `wr_secure`=0, write bits for IDs whose `irq_group` bit is 0 (group 0) are ignored. When `sec_en`=0, no bit is filtered.
- R8: Only bits written as 1 act. Zero bits have no effect. A write is visible on `pend_o` and `rd_data` after the rising edge that samples the strobe.
- R9: When a pending write and a target write hit the same shared ID in the same cycle, the pending write is combined with the new mask. A set applies to the new mask. A clear wins over a gain.
- R10: `rd_idx`=0 returns the private copy of `rd_cpu`. `rd_idx`≥1 returns, for each shared ID, the OR of its pending state across all CPUs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_en | input | 1 | Enables group-based filtering of non-secure writes |
| irq_group | input | NUM_IRQ | Group of each ID (0 = group 0, 1 = group 1) |
| wr_en | input | 1 | Pending-bank write strobe |
| wr_clr | input | 1 | 0 = set bank, 1 = clear bank |
| wr_idx | input | IDXW | Register index (IDs 32·idx to 32·idx+31) |
| wr_cpu | input | 3 | Number of the requesting CPU |
| wr_secure | input | 1 | Secure attribute of the write |
| wr_data | input | 32 | One bit per ID; 1 acts |
| tgt_en | input | 1 | Target-mask write strobe |
| tgt_id | input | IDW | Interrupt ID whose mask is written |
| tgt_mask | input | NUM_CPU | New target CPU mask |
| rd_idx | input | IDXW | Register index to read |
| rd_cpu | input | 3 | CPU whose view is read |
| rd_data | output | 32 | Pending bits of the selected register |
| pend_o | output | NUM_CPU·NUM_IRQ | Pending state; bit c·NUM_IRQ+i is ID i on CPU c |

## Verification
A pending-bank write and a target-mask write can reach the same shared ID in one clock cycle. That case needs its own resolution. The bench drives both strobes together on the same ID in two ways. In the first, a set on an ID with an empty mask meets a mask that names one CPU, and the ID must then be pending on that CPU. In the second, a clear meets a mask that widens to all CPUs, and the ID must end up pending nowhere. Each result is judged on `pend_o` and `rd_data` after the edge.

// File: rtl/irq_pend_dist.sv
module irq_pend_dist #(
  parameter int NUM_CPU = 8,
  parameter int NUM_IRQ = 64,
  localparam int NREG = NUM_IRQ / 32,
  localparam int NSHR = NUM_IRQ - 32,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IDW  = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sec_en,
  input  logic [NUM_IRQ-1:0]         irq_group,
  input  logic                       wr_en,
  input  logic                       wr_clr,
  input  logic [IDXW-1:0]            wr_idx,
  input  logic [2:0]                 wr_cpu,
  input  logic                       wr_secure,
  input  logic [31:0]                wr_data,
  input  logic                       tgt_en,
  input  logic [IDW-1:0]             tgt_id,
  input  logic [NUM_CPU-1:0]         tgt_mask,
  input  logic [IDXW-1:0]            rd_idx,
  input  logic [2:0]                 rd_cpu,
  output logic [31:0]                rd_data,
  output logic [NUM_CPU*NUM_IRQ-1:0] pend_o
);

  logic [31:0]        priv_q [NUM_CPU];
  logic [NSHR-1:0]    shr_q;
  logic [NUM_CPU-1:0] tgt_w [NSHR];
  logic [NUM_IRQ-1:0] shr_full;
  logic [31:0]        grp_w, wbits;
  logic               wr_ok;

  assign wr_ok    = wr_en && (int'(wr_cpu) < NUM_CPU) && (int'(wr_idx) < NREG);
  assign grp_w    = irq_group[{wr_idx, 5'b0} +: 32];
  assign wbits    = wr_ok ? (wr_data & ((sec_en && !wr_secure) ? grp_w : 32'hFFFF_FFFF)) : 32'h0;
  assign shr_full = {shr_q, 32'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) priv_q[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        if (wr_ok && wr_idx == '0 && int'(wr_cpu) == c)
          priv_q[c] <= wr_clr ? (priv_q[c] & ~wbits) : (priv_q[c] | wbits);
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_priv_chk
    AST_PRIV_SET_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !wr_clr && wr_idx == '0 && int'(wr_cpu) != c) |=> $stable(priv_q[c])); // R2
    AST_PRIV_SET_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !wr_clr && wr_idx == '0 && int'(wr_cpu) == c) |=> ((priv_q[c] & $past(wbits)) == $past(wbits))); // R2
    AST_PRIV_CLR_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_clr && wr_idx == '0 && int'(wr_cpu) != c) |=> $stable(priv_q[c])); // R3
    AST_PRIV_CLR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_clr && wr_idx == '0 && int'(wr_cpu) == c) |=> ((priv_q[c] & $past(wbits)) == 32'h0)); // R3
  end

  for (genvar j = 0; j < NSHR; j++) begin : g_shr
    localparam int ID = j + 32;
    localparam int RI = ID / 32;
    localparam int BI = ID % 32;
    logic               pq;
    logic [NUM_CPU-1:0] tq, tnext;
    logic               hit, tsel;

    assign hit   = wr_ok && int'(wr_idx) == RI && wbits[BI];
    assign tsel  = tgt_en && int'(tgt_id) == ID;
    assign tnext = tsel ? tgt_mask : tq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tq <= '0;
        pq <= 1'b0;
      end else begin
        tq <= tnext;
        pq <= (tnext != '0) && (hit ? !wr_clr : pq);
      end
    end

    assign shr_q[j] = pq;
    assign tgt_w[j] = tq;

    AST_SHR_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_clr && int'(wr_idx) == RI && wr_data[BI] && (irq_group[ID] || !sec_en || wr_secure)) |=> !pq); // R5
    AST_EMPTY_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_en && int'(tgt_id) == ID && tgt_mask == '0) |=> !pq); // R6
    AST_GRP0_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_en && !wr_secure && !irq_group[ID] && !(tgt_en && int'(tgt_id) == ID)) |=> (pq == $past(pq))); // R7
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == '0) begin
      if (int'(rd_cpu) < NUM_CPU) rd_data = priv_q[rd_cpu];
    end else if (int'(rd_idx) < NREG) begin
      rd_data = shr_full[{rd_idx, 5'b0} +: 32];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_out_c
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_out_i
      if (i < 32) begin : g_p
        assign pend_o[c*NUM_IRQ+i] = priv_q[c][i];
      end else begin : g_s
        assign pend_o[c*NUM_IRQ+i] = shr_q[i-32] & tgt_w[i-32][c];
      end
    end
  end

endmodule

// File: tb/irq_pend_dist_tb.sv
module irq_pend_dist_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 8;
  localparam int NIRQ = 64;

  logic clk = 0, rst_n = 0;
  logic sec_en = 1;
  logic [NIRQ-1:0] irq_group = 64'hFFFF_FFF0_FFFF_FFF0;
  logic wr_en = 0, wr_clr = 0, wr_secure = 0;
  logic [0:0] wr_idx = '0, rd_idx = '0;
  logic [2:0] wr_cpu = '0, rd_cpu = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic tgt_en = 0;
  logic [5:0] tgt_id = '0;
  logic [NCPU-1:0] tgt_mask = '0;
  logic [NCPU*NIRQ-1:0] pend_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_dist u_dut (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .irq_group(irq_group),
    .wr_en(wr_en), .wr_clr(wr_clr), .wr_idx(wr_idx), .wr_cpu(wr_cpu),
    .wr_secure(wr_secure), .wr_data(wr_data), .tgt_en(tgt_en), .tgt_id(tgt_id),
    .tgt_mask(tgt_mask), .rd_idx(rd_idx), .rd_cpu(rd_cpu), .rd_data(rd_data),
    .pend_o(pend_o)
  );

  // op: 0 set, 1 clear, 2 target (idx field = ID, data[7:0] = mask), 3 idle
  // {op, idx/id, cpu, secure, data, rd_idx, rd_cpu, expected rd_data}
  localparam logic [81:0] VEC [15] = '{
    {2'd0, 8'd0,  3'd1, 1'b1, 32'h0000_00F0, 1'b0, 3'd1, 32'h0000_00F0}, // R2 R10
    {2'd3, 8'd0,  3'd0, 1'b1, 32'h0000_0000, 1'b0, 3'd2, 32'h0000_0000}, // R2
    {2'd0, 8'd0,  3'd2, 1'b0, 32'h0000_000F, 1'b0, 3'd2, 32'h0000_0000}, // R7
    {2'd0, 8'd0,  3'd2, 1'b0, 32'h0000_0F0F, 1'b0, 3'd2, 32'h0000_0F00}, // R7
    {2'd1, 8'd0,  3'd2, 1'b1, 32'h0000_0100, 1'b0, 3'd2, 32'h0000_0E00}, // R3
    {2'd3, 8'd0,  3'd0, 1'b1, 32'h0000_0000, 1'b0, 3'd1, 32'h0000_00F0}, // R3
    {2'd0, 8'd1,  3'd0, 1'b1, 32'h0000_0010, 1'b1, 3'd0, 32'h0000_0000}, // R4
    {2'd2, 8'd36, 3'd0, 1'b1, 32'h0000_0006, 1'b1, 3'd0, 32'h0000_0000}, // R6
    {2'd0, 8'd1,  3'd0, 1'b1, 32'h0000_0010, 1'b1, 3'd0, 32'h0000_0010}, // R4
    {2'd2, 8'd33, 3'd0, 1'b1, 32'h0000_0001, 1'b1, 3'd0, 32'h0000_0010}, // R6
    {2'd0, 8'd1,  3'd5, 1'b1, 32'h0000_0002, 1'b1, 3'd0, 32'h0000_0012}, // R4
    {2'd1, 8'd1,  3'd3, 1'b1, 32'h0000_0010, 1'b1, 3'd0, 32'h0000_0002}, // R5
    {2'd2, 8'd33, 3'd0, 1'b1, 32'h0000_0000, 1'b1, 3'd0, 32'h0000_0000}, // R6
    {2'd0, 8'd1,  3'd4, 1'b0, 32'h0000_00FF, 1'b1, 3'd0, 32'h0000_0010}, // R7
    {2'd0, 8'd1,  3'd4, 1'b1, 32'h0000_0000, 1'b1, 3'd0, 32'h0000_0010}  // R8
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic clr, input logic [0:0] idx, input logic [2:0] cpu,
                    input logic sec, input logic [31:0] data);
    wr_en = 1; wr_clr = clr; wr_idx = idx; wr_cpu = cpu; wr_secure = sec; wr_data = data;
  endtask

  task automatic tw(input logic [5:0] id, input logic [7:0] m);
    tgt_en = 1; tgt_id = id; tgt_mask = m;
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 0; tgt_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pend_o low word", pend_o[31:0], 32'h0);
    chk("R1 pend_o any", {31'b0, |pend_o}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 15; k++) begin
      logic [81:0] v;
      v = VEC[k];
      case (v[81:80])
        2'd0: wr(1'b0, v[72], v[71:69], v[68], v[67:36]);
        2'd1: wr(1'b1, v[72], v[71:69], v[68], v[67:36]);
        2'd2: tw(v[77:72], v[43:36]);
        default: ;
      endcase
      rd_idx = v[35]; rd_cpu = v[34:32];
      step();
      chk($sformatf("R8 table row %0d", k), rd_data, v[31:0]);
    end

    // ID 36 pending, mask 0x06
    chk("R4 cpu1 id36", {31'b0, pend_o[1*NIRQ+36]}, 32'h1);
    chk("R4 cpu3 id36 not targeted", {31'b0, pend_o[3*NIRQ+36]}, 32'h0);
    tw(6'd36, 8'h0C); step();
    chk("R6 cpu1 removed", {31'b0, pend_o[1*NIRQ+36]}, 32'h0);
    chk("R6 cpu2 kept", {31'b0, pend_o[2*NIRQ+36]}, 32'h1);
    chk("R6 cpu3 added", {31'b0, pend_o[3*NIRQ+36]}, 32'h1);

    tw(6'd5, 8'hFF); step();
    rd_idx = 1'b0; rd_cpu = 3'd1; #1;
    chk("R6 private target ignored cpu1", rd_data, 32'h0000_00F0);
    chk("R6 private target ignored cpu0 id5", {31'b0, pend_o[0*NIRQ+5]}, 32'h0);

    // R9: set on empty-mask ID 40 together with mask 0x80
    wr(1'b0, 1'b1, 3'd0, 1'b1, 32'h0000_0100); tw(6'd40, 8'h80); step();
    rd_idx = 1'b1; #1;
    chk("R9 set with new mask cpu7", {31'b0, pend_o[7*NIRQ+40]}, 32'h1);
    chk("R9 set with new mask cpu0", {31'b0, pend_o[0*NIRQ+40]}, 32'h0);
    chk("R9 rd after set", rd_data, 32'h0000_0110);
    // R9: clear of ID 36 together with widening mask
    wr(1'b1, 1'b1, 3'd0, 1'b1, 32'h0000_0010); tw(6'd36, 8'hFF); step();
    chk("R9 clear beats gain cpu0", {31'b0, pend_o[0*NIRQ+36]}, 32'h0);
    chk("R9 clear beats gain cpu2", {31'b0, pend_o[2*NIRQ+36]}, 32'h0);
    chk("R9 rd after clear", rd_data, 32'h0000_0100);

    // R7: filtering off
    sec_en = 0;
    wr(1'b0, 1'b0, 3'd0, 1'b0, 32'h0000_0001); step();
    rd_idx = 1'b0; rd_cpu = 3'd0; #1;
    chk("R7 no filter when disabled", rd_data, 32'h0000_0001);
    wr(1'b0, 1'b1, 3'd6, 1'b0, 32'h0000_0001); step();
    chk("R7 shared grp0 unfiltered cpu7 id32 mask empty", {31'b0, pend_o[7*NIRQ+32]}, 32'h0);
    tw(6'd32, 8'h40); wr(1'b0, 1'b1, 3'd6, 1'b0, 32'h0000_0001); step();
    chk("R7 shared grp0 unfiltered cpu6 id32", {31'b0, pend_o[6*NIRQ+32]}, 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule